// File: doc/BRIEF.md
# Coded Reference Rate Divider

This block turns a free-running reference clock into a comparison-rate strobe for a frequency synthesiser. A 4-bit ratio code chooses one of fifteen division ratios. The ratios come from two families: powers of two from 2 to 256, and five times a power of two from 5 to 320. Code `1000` is reserved. Writing it raises a flag and leaves the current ratio in force. For example, with a 4 MHz reference, code `0000` gives a 2 MHz strobe and code `1111` gives 12.5 kHz.

A control path presents the code on `ratio_code_i` and pulses `code_load_i` for one clock. The decoded ratio is held pending. It replaces the running ratio only on the clock edge where the current division period ends, so every period is whole and there is no runt or stretched strobe.

The apply controller has two states. `APPLY_IDLE` means no ratio is pending. `APPLY_ARMED` means a valid ratio waits for the next terminal count. The transitions are:
- `LOAD_OK`: IDLE→ARMED, on a strobe carrying a valid code.
- `ADOPT`: ARMED→IDLE, on a terminal count.
- `ADOPT_RELOAD`: ARMED→ARMED, on a terminal count with a valid strobe in the same cycle.
- `REFRESH`: ARMED→ARMED, on a valid strobe without a terminal count.

Any other cycle holds the state. A strobe carrying the reserved code never changes state.

Top module: `ref_rate_divider`

## Requirements
- R1: Codes 0 to 7 (bit 3 clear) divide by 2^(code+1): 2, 4, 8, 16, 32, 64, 128, 256.
- R2: Code 8 (`1000`) is reserved. At the clock edge that samples its load strobe, `code_bad_o` goes to 1, and the ratio in force (and any pending valid ratio) stays unchanged.
- R3: Codes 9 to 15 divide by 5·2^(code−9): 5, 10, 20, 40, 80, 160, 320.
- R4: `cmp_pulse_o` is high for exactly one reference clock once per division period. Consecutive rising edges of the strobe are exactly the ratio apart.
- R5: A newly loaded ratio takes effect only at the next terminal count. The period in progress when the code is loaded still lasts the old ratio, and the following periods use the new one.
- R6: While `rst_n` is low, `cmp_pulse_o` and `code_bad_o` stay 0. After release the ratio is 2, and the first strobe appears on the second rising clock edge.
- R7: A load of a valid code clears `code_bad_o` at the sampling edge. A reserved-code load that follows a valid load in the same period does not cancel the pending valid ratio.
- R8: While `code_load_i` is low, `ratio_code_i` has no effect on the division period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ratio_code_i | input | 4 | Division ratio code |
| code_load_i | input | 1 | One-cycle strobe that samples `ratio_code_i` |
| cmp_pulse_o | output | 1 | One-cycle comparison-rate strobe |
| code_bad_o | output | 1 | Last loaded code was the reserved one |

## Verification
The assertions assume `code_load_i` and `ratio_code_i` are stable around the rising edge and free of unknown values once reset is released. The bench meets this by driving every input only on the falling edge, holding each load strobe for exactly one cycle, and keeping the code valid for the same cycle. The assertions also assume a load never lands on the reset edge. The bench therefore only loads after reset has been released, and it waits for the adoption strobe before it measures any period.

// File: rtl/refdiv_pkg.sv
package refdiv_pkg;

    localparam int CODE_W  = 4;
    localparam int RATIO_W = 9;
    localparam int N_CODES = 1 << CODE_W;

    typedef logic [RATIO_W-1:0] ratio_t;

    typedef enum logic [0:0] {
        APPLY_IDLE  = 1'b0,
        APPLY_ARMED = 1'b1
    } apply_state_e;

    // Ratio for a code; zero marks the reserved code.
    function automatic ratio_t ratio_of(input logic [CODE_W-1:0] code);
        ratio_t r;
        if (!code[CODE_W-1]) begin
            r = ratio_t'(2) << code[CODE_W-2:0];
        end else if (code[CODE_W-2:0] == '0) begin
            r = '0;
        end else begin
            r = ratio_t'(5) << (code[CODE_W-2:0] - 3'd1);
        end
        return r;
    endfunction

endpackage

// File: rtl/refdiv_code_decode.sv
module refdiv_code_decode
    import refdiv_pkg::*;
(
    input  logic [CODE_W-1:0] code_i,
    output ratio_t            ratio_o,
    output logic              valid_o
);

    ratio_t table_q [N_CODES];

    for (genvar g = 0; g < N_CODES; g++) begin : g_tbl
        assign table_q[g] = ratio_of(CODE_W'(g));
    end

    always_comb begin
        ratio_o = table_q[code_i];
        valid_o = (ratio_o != '0);
    end

    // R1 R3: every valid code decodes to a ratio of at least two
    always_comb begin
        if (valid_o) begin
            decode_min_chk: assert (ratio_o >= ratio_t'(2))
                else $error("decode_min_chk: ratio below two");
        end
    end

endmodule

// File: rtl/refdiv_apply_fsm.sv
module refdiv_apply_fsm
    import refdiv_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   load_i,
    input  logic   load_valid_i,
    input  ratio_t load_ratio_i,
    input  logic   term_i,
    output ratio_t active_o,
    output logic   bad_o
);

    apply_state_e state_q, state_d;
    ratio_t       pend_q;
    ratio_t       active_q;
    logic         bad_q;

    logic load_ok;
    logic load_bad;
    assign load_ok  = load_i && load_valid_i;
    assign load_bad = load_i && !load_valid_i;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= APPLY_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            APPLY_IDLE: begin
                if (load_ok) state_d = APPLY_ARMED;          // LOAD_OK
            end
            APPLY_ARMED: begin
                if (term_i && !load_ok) state_d = APPLY_IDLE; // ADOPT
                else state_d = APPLY_ARMED;                   // ADOPT_RELOAD / REFRESH / hold
            end
            default: state_d = APPLY_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q   <= ratio_t'(2);
            active_q <= ratio_t'(2);
            bad_q    <= 1'b0;
        end else begin
            if (state_q == APPLY_ARMED && term_i) begin
                active_q <= pend_q;
            end
            if (load_ok) begin
                pend_q <= load_ratio_i;
                bad_q  <= 1'b0;
            end else if (load_bad) begin
                bad_q  <= 1'b1;
            end
        end
    end

    assign active_o = active_q;
    assign bad_o    = bad_q;

    // R2
    bad_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_bad |=> bad_q)
        else $error("bad_set_chk");

    // R7
    bad_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_ok |=> !bad_q)
        else $error("bad_clear_chk");

    // R5
    ratio_at_term_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !term_i |=> $stable(active_q))
        else $error("ratio_at_term_chk");

    // R2
    bad_keeps_ratio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_bad && state_q == APPLY_IDLE) |=> $stable(active_q))
        else $error("bad_keeps_ratio_chk");

endmodule

// File: rtl/refdiv_counter.sv
module refdiv_counter
    import refdiv_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  ratio_t ratio_i,
    output logic   term_o,
    output logic   pulse_o
);

    ratio_t cnt_q;
    logic   pulse_q;

    assign term_o = (cnt_q == ratio_i - ratio_t'(1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            pulse_q <= 1'b0;
        end else if (term_o) begin
            cnt_q   <= '0;
            pulse_q <= 1'b1;
        end else begin
            cnt_q   <= cnt_q + ratio_t'(1);
            pulse_q <= 1'b0;
        end
    end

    assign pulse_o = pulse_q;

    // R4
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_q |=> !pulse_q)
        else $error("pulse_single_chk");

    // R4
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < ratio_i)
        else $error("cnt_range_chk");

endmodule

// File: rtl/ref_rate_divider.sv
module ref_rate_divider
    import refdiv_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] ratio_code_i,
    input  logic              code_load_i,
    output logic              cmp_pulse_o,
    output logic              code_bad_o
);

    ratio_t dec_ratio;
    logic   dec_valid;
    ratio_t active_ratio;
    logic   term;

    refdiv_code_decode u_decode (
        .code_i  (ratio_code_i),
        .ratio_o (dec_ratio),
        .valid_o (dec_valid)
    );

    refdiv_apply_fsm u_apply (
        .clk          (clk),
        .rst_n        (rst_n),
        .load_i       (code_load_i),
        .load_valid_i (dec_valid),
        .load_ratio_i (dec_ratio),
        .term_i       (term),
        .active_o     (active_ratio),
        .bad_o        (code_bad_o)
    );

    refdiv_counter u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .ratio_i (active_ratio),
        .term_o  (term),
        .pulse_o (cmp_pulse_o)
    );

    // R6
    no_pulse_in_reset_chk: assert property (@(posedge clk)
        !rst_n |=> !cmp_pulse_o && !code_bad_o)
        else $error("no_pulse_in_reset_chk");

endmodule

// File: tb/ref_rate_divider_bench.sv
`timescale 1ns/1ps
module ref_rate_divider_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] code = 4'd0;
    logic       load = 1'b0;
    logic       pulse;
    logic       bad;

    int checks = 0;
    int fails  = 0;

    localparam int EXP_RATIO [16] = '{2, 4, 8, 16, 32, 64, 128, 256,
                                      256, 5, 10, 20, 40, 80, 160, 320};

    always #2 clk = ~clk;

    ref_rate_divider u_ref_rate_divider (
        .clk          (clk),
        .rst_n        (rst_n),
        .ratio_code_i (code),
        .code_load_i  (load),
        .cmp_pulse_o  (pulse),
        .code_bad_o   (bad)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Wait for the next strobe (not the current one).
    task automatic wait_pulse(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!pulse && n < 2000);
    endtask

    // Period from the current strobe to the next, with a width check.
    task automatic measure(input string req, input int exp);
        int n;
        n = 0;
        @(negedge clk);
        n++;
        check(!pulse, "R4 width", int'(pulse), 0);
        while (!pulse && n < 2000) begin
            @(negedge clk);
            n++;
        end
        check(n == exp, req, n, exp);
    endtask

    task automatic load_code(input logic [3:0] c);
        @(negedge clk);
        code = c;
        load = 1'b1;
        @(negedge clk);
        load = 1'b0;
    endtask

    initial begin
        int n;
        int m;

        // R6: reset holds outputs low
        repeat (10) begin
            @(negedge clk);
            check(!pulse && !bad, "R6 reset", int'({pulse, bad}), 0);
        end
        rst_n = 1'b1;
        wait_pulse(n);
        check(n == 2, "R6 first strobe", n, 2);
        measure("R6 default ratio", 2);

        // Table walk: R1 codes 0..7, R2 code 8, R3 codes 9..15
        for (int i = 0; i < 16; i++) begin
            load_code(4'(i));
            check(bad == (i == 8), (i == 8) ? "R2 flag" : "R7 flag clear",
                  int'(bad), int'(i == 8));
            wait_pulse(n);
            measure((i < 8) ? "R1 ratio" : (i == 8) ? "R2 ratio kept" : "R3 ratio",
                    EXP_RATIO[i]);
            measure("R4 repeat period", EXP_RATIO[i]);
        end

        // R5: load mid-period at ratio 320, old period completes
        repeat (5) @(negedge clk);
        code = 4'd0;
        load = 1'b1;
        @(negedge clk);
        load = 1'b0;
        wait_pulse(m);
        check(m + 6 == 320, "R5 old period kept", m + 6, 320);
        measure("R5 new ratio", 2);

        // R7: reserved load after a valid load keeps the pending ratio
        load_code(4'd15);
        wait_pulse(n);
        measure("R3 ratio 320", 320);
        load_code(4'd1);
        load_code(4'd8);
        check(bad, "R7 flag set", int'(bad), 1);
        wait_pulse(n);
        measure("R7 pending kept", 4);
        load_code(4'd3);
        check(!bad, "R7 flag clear", int'(bad), 0);
        wait_pulse(n);
        measure("R1 ratio 16", 16);

        // R8: code changes without a load have no effect
        code = 4'd9;
        measure("R8 ignored", 16);
        code = 4'd0;
        measure("R8 ignored", 16);

        // R6: reset in mid-run
        @(negedge clk);
        rst_n = 1'b0;
        repeat (5) begin
            @(negedge clk);
            check(!pulse && !bad, "R6 reset mid-run", int'({pulse, bad}), 0);
        end
        rst_n = 1'b1;
        wait_pulse(n);
        check(n == 2, "R6 first strobe again", n, 2);
        measure("R6 ratio after reset", 2);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(4 * 150000);
        checks++;
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule